// File: doc/BRIEF.md
# Two-Phase Quadrature Position Decoder

This block turns a two-phase rotary encoder signal into a wrapping position count. Every change of level on phase A, rising or falling, samples the level of phase B, and the pair of levels tells which way the shaft turned. A quarter step in which only phase B moves does not count. A full encoder cycle walks through four level states and gives two counts, one for each phase A transition.

The count runs between zero and a programmable top value. Counting up past the top wraps the count to zero and raises a sticky overflow flag. Counting down past zero reloads the top value and raises a sticky underflow flag. The most recent decoded direction is held as a status bit. A separate sticky flag marks each step whose direction differs from the step before it. An invert input reverses the decoded sense, so the same wiring can serve either mounting of the encoder. Decoding runs only while the two-bit mode input holds the quadrature mode code. The phase inputs are taken to be synchronous to the block clock already, and there is no pulse-width filter.

Top module: `qdec_top`

## Requirements
- R1: After reset the count is 0, the top value is all ones (255 at the default width), the direction status is 1 (up), and all three flags are 0.
- R2: A step happens only on a clock edge where phase A differs from its level one clock earlier. Changes on phase B alone never change the count, the direction or any flag. A full four-state cycle gives two counts.
- R3: On a step the decoded direction is up when the new phase A level differs from phase B. That means A rising with B low, or A falling with B high: A leads B. Otherwise the decoded direction is down. Up adds one to the count and down subtracts one.
- R4: With the invert input at 1, the decoded direction of every step is reversed before it is counted and stored.
- R5: Steps are decoded only while the mode input equals 2'b11. With any other mode value, phase A transitions leave the count, the direction status and the flags unchanged.
- R6: An up step taken while the count equals the top value sets the count to 0 and sets the overflow flag.
- R7: A down step taken while the count is 0 loads the current top value into the count and sets the underflow flag.
- R8: The direction status output holds the direction of the latest step (1 up, 0 down) and changes only on a step.
- R9: The direction-change flag is set by a step whose direction differs from the stored direction. It is never set by the first step after reset.
- R10: The flags are sticky. Flag-clear bit 0 clears overflow, bit 1 clears underflow and bit 2 clears direction change. A flag that is set and cleared in the same cycle stays set.
- R11: A count load pulse writes the count value in the next cycle, ahead of any step in the same cycle, and that step then causes no wrap. A top load pulse writes the top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode; 2'b11 enables quadrature decoding |
| phase_a | input | 1 | Encoder phase A, used as the sampling event |
| phase_b | input | 1 | Encoder phase B, sampled on phase A transitions |
| dir_invert | input | 1 | Reverses the decoded direction |
| top_load | input | 1 | Writes top_value into the top register |
| top_value | input | 8 | New top (wrap) value |
| cnt_load | input | 1 | Writes cnt_value into the count |
| cnt_value | input | 8 | New count value |
| flag_clr | input | 3 | Per-flag clear: bit 0 overflow, bit 1 underflow, bit 2 direction change |
| count | output | 8 | Current position count |
| dir_up | output | 1 | Latest decoded direction, 1 = up |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |
| dirchg_flag | output | 1 | Sticky direction-change flag |

## Verification
The bench walks encoder states that mix phase A steps with phase B-only quarter steps and reverses the rotation halfway through. A decoder that counted phase B edges, or swapped the rising and falling rules, would drift off the expected counts in that walk. It forces a wrap at a reloaded top and, separately, an underflow as the very first step after reset, which catches a reload from a stale top and a direction-change flag raised spuriously against the reset direction. It also collides a count load with a step and a flag clear with a new wrap, exposing a wrong priority in either case.

// File: rtl/qdec_pkg.sv
`timescale 1ns/1ps
package qdec_pkg;

  // mode code that enables the decoder
  localparam logic [1:0] MODE_QUAD = 2'b11;

  // sticky flag slots, shared by the flag bank and the clear input
  localparam int FLAG_N    = 3;
  localparam int FLAG_OVF  = 0;
  localparam int FLAG_UNF  = 1;
  localparam int FLAG_DCHG = 2;

  // Direction of one phase-A step. A leads B exactly when the new A level
  // and the B level disagree; the invert input flips the result.
  function automatic logic phase_step_up(input logic a_level,
                                         input logic b_level,
                                         input logic invert);
    return (a_level ^ b_level) ^ invert;
  endfunction

endpackage

// File: rtl/qdec_edge_sampler.sv
`timescale 1ns/1ps
module qdec_edge_sampler
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       phase_a,
  input  logic       phase_b,
  input  logic       invert,
  output logic       edge_evt,
  output logic       step_up
);

  logic a_prev;
  logic mode_on;
  logic a_moved;

  // last seen phase A level; tracked in every mode so that switching the
  // decoder on does not see a stale transition
  always_ff @(posedge clk) begin
    if (!rst_n) a_prev <= 1'b0;
    else        a_prev <= phase_a;
  end

  always_comb begin
    mode_on  = (mode == MODE_QUAD);
    a_moved  = (phase_a != a_prev);
    edge_evt = mode_on && a_moved;
    step_up  = phase_step_up(phase_a, phase_b, invert);
  end

endmodule

// File: rtl/qdec_dir_track.sv
`timescale 1ns/1ps
module qdec_dir_track (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_evt,
  input  logic step_up,
  output logic dir_up,
  output logic dchg_evt
);

  logic dir_q;
  logic seen_q;

  // a change needs a previous decoded step to compare against
  always_comb dchg_evt = edge_evt && seen_q && (step_up != dir_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b1;
      seen_q <= 1'b0;
    end else if (edge_evt) begin
      dir_q  <= step_up;
      seen_q <= 1'b1;
    end
  end

  assign dir_up = dir_q;

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_evt |=> $stable(dir_q)); // R8

  AST_DCHG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    dchg_evt |=> (dir_q != $past(dir_q))); // R9

endmodule

// File: rtl/qdec_wrap_counter.sv
`timescale 1ns/1ps
module qdec_wrap_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_evt,
  input  logic         step_up,
  input  logic         cnt_load,
  input  logic [W-1:0] cnt_value,
  input  logic         top_load,
  input  logic [W-1:0] top_value,
  output logic [W-1:0] count,
  output logic         ovf_evt,
  output logic         unf_evt
);

  localparam logic [W-1:0] CNT_ZERO = '0;
  localparam logic [W-1:0] TOP_INIT = '1;
  localparam logic [W-1:0] CNT_ONE  = W'(1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] top_q;
  logic [W-1:0] cnt_step;
  logic         step_live;

  // one step of a counter that runs between zero and top
  function automatic logic [W-1:0] wrap_step(input logic [W-1:0] cur,
                                             input logic [W-1:0] top,
                                             input logic         up);
    if (up) return (cur == top)      ? CNT_ZERO : cur + CNT_ONE;
    else    return (cur == CNT_ZERO) ? top      : cur - CNT_ONE;
  endfunction

  always_comb begin
    step_live = edge_evt && !cnt_load;
    cnt_step  = wrap_step(cnt_q, top_q, step_up);
    ovf_evt   = step_live &&  step_up && (cnt_q == top_q);
    unf_evt   = step_live && !step_up && (cnt_q == CNT_ZERO);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
      top_q <= TOP_INIT;
    end else begin
      if (cnt_load)      cnt_q <= cnt_value;
      else if (edge_evt) cnt_q <= cnt_step;
      if (top_load)      top_q <= top_value;
    end
  end

  assign count = cnt_q;

  AST_OVF_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == CNT_ZERO)); // R6

  AST_UNF_TO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> (cnt_q == $past(top_q))); // R7

  AST_ONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_evt, unf_evt})); // R6

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_evt && !cnt_load) |=> $stable(cnt_q)); // R2

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_live && step_up && !ovf_evt) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R3

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (cnt_q == $past(cnt_value))); // R11

endmodule

// File: rtl/qdec_flag_bank.sv
`timescale 1ns/1ps
module qdec_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] flags
);

  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (set_vec[i]) flag_q[i] <= 1'b1;
      else if (clr_vec[i]) flag_q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flag_q[i]); // R10

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]); // R10

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_vec[i] && !set_vec[i]) |=> $stable(flag_q[i])); // R10
  end

  assign flags = flag_q;

endmodule

// File: rtl/qdec_top.sv
`timescale 1ns/1ps
module qdec_top
  import qdec_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         phase_a,
  input  logic         phase_b,
  input  logic         dir_invert,
  input  logic         top_load,
  input  logic [W-1:0] top_value,
  input  logic         cnt_load,
  input  logic [W-1:0] cnt_value,
  input  logic [2:0]   flag_clr,
  output logic [W-1:0] count,
  output logic         dir_up,
  output logic         ovf_flag,
  output logic         unf_flag,
  output logic         dirchg_flag
);

  // internal events, named for the assertions
  logic              edge_evt;
  logic              step_up;
  logic              dchg_evt;
  logic              ovf_evt;
  logic              unf_evt;
  logic [FLAG_N-1:0] flag_set;
  logic [FLAG_N-1:0] flag_vec;

  qdec_edge_sampler u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .phase_a  (phase_a),
    .phase_b  (phase_b),
    .invert   (dir_invert),
    .edge_evt (edge_evt),
    .step_up  (step_up)
  );

  qdec_dir_track u_dir (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_evt (edge_evt),
    .step_up  (step_up),
    .dir_up   (dir_up),
    .dchg_evt (dchg_evt)
  );

  qdec_wrap_counter #(.W(W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_evt  (edge_evt),
    .step_up   (step_up),
    .cnt_load  (cnt_load),
    .cnt_value (cnt_value),
    .top_load  (top_load),
    .top_value (top_value),
    .count     (count),
    .ovf_evt   (ovf_evt),
    .unf_evt   (unf_evt)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_OVF]  = ovf_evt;
    flag_set[FLAG_UNF]  = unf_evt;
    flag_set[FLAG_DCHG] = dchg_evt;
  end

  qdec_flag_bank #(.N(FLAG_N)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (flag_set),
    .clr_vec (flag_clr),
    .flags   (flag_vec)
  );

  assign ovf_flag    = flag_vec[FLAG_OVF];
  assign unf_flag    = flag_vec[FLAG_UNF];
  assign dirchg_flag = flag_vec[FLAG_DCHG];

  // phase B moving alone must not disturb the position
  AST_B_ALONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(phase_a) && !cnt_load) |=> $stable(count)); // R2

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_QUAD && !cnt_load) |=> ($stable(count) && $stable(dir_up))); // R5

endmodule

// File: tb/qdec_top_tb.sv
`timescale 1ns/1ps
module qdec_top_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       phase_a, phase_b, dir_invert;
  logic       top_load, cnt_load;
  logic [7:0] top_value, cnt_value;
  logic [2:0] flag_clr;
  logic [7:0] count;
  logic       dir_up, ovf_flag, unf_flag, dirchg_flag;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  qdec_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .phase_a(phase_a), .phase_b(phase_b),
    .dir_invert(dir_invert), .top_load(top_load), .top_value(top_value),
    .cnt_load(cnt_load), .cnt_value(cnt_value), .flag_clr(flag_clr),
    .count(count), .dir_up(dir_up), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .dirchg_flag(dirchg_flag)
  );

  // vector: [10] phase A, [9] phase B, [8:1] expected count, [0] expected dir
  localparam logic [10:0] VEC [12] = '{
    {1'b1, 1'b0, 8'd1,   1'b1},  // A rises, B low: up
    {1'b1, 1'b1, 8'd1,   1'b1},  // B only: no count
    {1'b0, 1'b1, 8'd2,   1'b1},  // A falls, B high: up
    {1'b0, 1'b0, 8'd2,   1'b1},  // B only
    {1'b1, 1'b0, 8'd3,   1'b1},  // up
    {1'b0, 1'b0, 8'd2,   1'b0},  // A falls, B low: down (reversal)
    {1'b0, 1'b1, 8'd2,   1'b0},  // B only
    {1'b1, 1'b1, 8'd1,   1'b0},  // A rises, B high: down
    {1'b1, 1'b0, 8'd1,   1'b0},  // B only
    {1'b0, 1'b0, 8'd0,   1'b0},  // down to zero
    {1'b0, 1'b1, 8'd0,   1'b0},  // B only
    {1'b1, 1'b1, 8'd255, 1'b0}   // down from zero: reload top 255
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic apply(input logic a, input logic b, input logic cl, input logic [7:0] cv,
                       input logic tl, input logic [7:0] tv, input logic [2:0] clr);
    phase_a   = a;  phase_b   = b;
    cnt_load  = cl; cnt_value = cv;
    top_load  = tl; top_value = tv;
    flag_clr  = clr;
    @(negedge clk);
    cnt_load = 1'b0; top_load = 1'b0; flag_clr = 3'b000;
  endtask

  task automatic step(input logic a, input logic b);
    apply(a, b, 1'b0, 8'd0, 1'b0, 8'd0, 3'b000);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'b11; phase_a = 1'b0; phase_b = 1'b0; dir_invert = 1'b0;
    top_load = 1'b0; cnt_load = 1'b0; top_value = 8'd0; cnt_value = 8'd0; flag_clr = 3'b000;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 count", count, 8'd0);
    chk("R1 dir", {7'd0, dir_up}, 8'd1);
    chk("R1 flags", {5'd0, dirchg_flag, unf_flag, ovf_flag}, 8'd0);

    // R2 R3 R8 R7: table walk through forward and reverse rotation
    for (int i = 0; i < 12; i++) begin
      step(VEC[i][10], VEC[i][9]);
      chk($sformatf("R2/R3 vec%0d count", i), count, VEC[i][8:1]);
      chk($sformatf("R8 vec%0d dir", i), {7'd0, dir_up}, {7'd0, VEC[i][0]});
    end
    chk("R7 unf flag", {7'd0, unf_flag}, 8'd1);
    chk("R9 dirchg after reversal", {7'd0, dirchg_flag}, 8'd1);
    chk("R6 no ovf yet", {7'd0, ovf_flag}, 8'd0);

    // R10 clear all flags
    apply(1'b1, 1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 3'b111);
    chk("R10 cleared", {5'd0, dirchg_flag, unf_flag, ovf_flag}, 8'd0);

    // R11 load count and top, then R6 wrap at top
    apply(1'b1, 1'b1, 1'b1, 8'd5, 1'b1, 8'd5, 3'b000);
    chk("R11 count load", count, 8'd5);
    step(1'b0, 1'b1);  // A falls, B high: up at top
    chk("R6 wrap to zero", count, 8'd0);
    chk("R6 ovf flag", {7'd0, ovf_flag}, 8'd1);
    chk("R9 dirchg down->up", {7'd0, dirchg_flag}, 8'd1);
    apply(1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 3'b111);

    // R4 invert: A rises with B high decodes down, inverted to up
    dir_invert = 1'b1;
    step(1'b1, 1'b1);
    chk("R4 inverted count", count, 8'd1);
    chk("R4 inverted dir", {7'd0, dir_up}, 8'd1);
    chk("R9 no change same dir", {7'd0, dirchg_flag}, 8'd0);

    // R5 other mode ignores phase A transitions
    mode = 2'b01;
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b0);
    chk("R5 count held", count, 8'd1);
    chk("R5 dir held", {7'd0, dir_up}, 8'd1);
    chk("R5 flags held", {5'd0, dirchg_flag, unf_flag, ovf_flag}, 8'd0);
    mode = 2'b11;
    dir_invert = 1'b0;

    // R11 load beats a step in the same cycle (A rises, B low: up)
    apply(1'b1, 1'b0, 1'b1, 8'd3, 1'b0, 8'd0, 3'b000);
    chk("R11 load over step", count, 8'd3);

    // R10 set wins over clear in the same cycle
    apply(1'b1, 1'b0, 1'b1, 8'd5, 1'b0, 8'd0, 3'b000);
    apply(1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 3'b001);  // A falls, B high: up at top 5
    chk("R6 wrap again", count, 8'd0);
    chk("R10 set beats clear", {7'd0, ovf_flag}, 8'd1);
    apply(1'b0, 1'b1, 1'b0, 8'd0, 1'b0, 8'd0, 3'b001);
    chk("R10 clear drops", {7'd0, ovf_flag}, 8'd0);

    // R9 first step after reset is down: no change flag, reload reset top
    phase_a = 1'b0; phase_b = 1'b0;
    do_reset();
    chk("R1 count after reset", count, 8'd0);
    step(1'b1, 1'b1);
    chk("R7 reload reset top", count, 8'd255);
    chk("R8 first dir down", {7'd0, dir_up}, 8'd0);
    chk("R9 no flag on first step", {7'd0, dirchg_flag}, 8'd0);
    chk("R7 unf on first step", {7'd0, unf_flag}, 8'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule